// File: doc/BRIEF.md
# Two-Flop Single-Bit Clock Domain Synchronizer with Step Counter

This block moves one bit from a source clock domain into an unrelated destination clock domain. On the source side a launch flop, clocked by the source clock, takes the sent bit whenever the send enable is high. On the destination side a chain of capture flops, clocked by the destination clock, gives a possibly metastable first stage one full destination period to settle. Only the last stage drives the read output. The first capture flop receives the launch flop output directly, with no logic in the path, and no other logic reads it.

A small wrapper uses the synchronized bit to steer a counter in the destination domain. The counter advances once in every destination cycle in which the read bit is 1. The bit crossing can lose information. If the source toggles faster than the destination samples, some transitions are never seen. Several copies of this block must not be used to carry a multi-bit word, because each bit may resolve in a different destination cycle. Each domain has its own active-low asynchronous reset.

Top module: `xdom_bit_counter`

## Requirements
- R1: A low `src_rst_ni` clears the launch flop to 0 and nothing else. The destination counter is not cleared. Once the cleared launch value has crossed, the read output shows 0.
- R2: A low `dst_rst_ni` drives the capture stages and `count_o` to 0 at once, without waiting for a clock edge. It leaves the launch flop unchanged, so after release the read output returns to the value last launched, with no new send.
- R3: On a source clock edge with `send_en_i` = 1, the launch flop loads `send_bit_i`. With `send_en_i` = 0, it keeps its value, and changes on `send_bit_i` never reach `read_bit_o`.
- R4: When the source and destination edges do not coincide, `read_bit_o` still shows the old value after the first destination edge that follows a launch flop update. It shows the new value by the third such edge.
- R5: `count_o` increases by exactly 1 in every destination cycle in which `read_bit_o` was 1 before the edge. It holds its value when `read_bit_o` was 0. It wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| send_en_i | input | 1 | Source-domain load enable for the launch flop |
| send_bit_i | input | 1 | Bit to be sent, sampled on the source clock |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| read_bit_o | output | 1 | Synchronized bit, driven by the last capture stage |
| count_o | output | CNT_W (32) | Destination counter, stepped while the read bit is 1 |

## Verification
The assertions assume that the send inputs change only away from source clock edges. They also assume that no destination reset pulse starts and ends between two destination edges. The bench drives all source inputs on the source falling edge. It asserts and releases the destination reset on destination falling edges, with at least one rising edge in between. The two clocks use periods of 4 ns and 7 ns, phased so that their rising edges never coincide. This makes the one-edge and three-edge latency bounds exact to check. The bench holds each sent value for many destination cycles. As a result the lossy fast-to-slow case never occurs, and every transition is expected to arrive.

// File: rtl/xbit_sync_pkg.sv
package xbit_sync_pkg;
  localparam int unsigned MIN_STAGES = 2;

  function automatic int unsigned clamp_stages(int unsigned n);
    return (n < MIN_STAGES) ? MIN_STAGES : n;
  endfunction
endpackage

// File: rtl/xbit_launch.sv
module xbit_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (en_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/xbit_capture.sv
module xbit_capture #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  localparam int unsigned N = xbit_sync_pkg::clamp_stages(STAGES);

  logic [N-1:0] chain_q;

  // stage 0 takes the crossing directly; only stage N-1 leaves the module
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[N-2:0], async_i};
  end

  assign sync_o = chain_q[N-1];
endmodule

// File: rtl/xbit_step_counter.sv
module xbit_step_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/xdom_bit_counter.sv
module xdom_bit_counter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 32
) (
  input  logic             src_clk_i,
  input  logic             src_rst_ni,
  input  logic             send_en_i,
  input  logic             send_bit_i,
  input  logic             dst_clk_i,
  input  logic             dst_rst_ni,
  output logic             read_bit_o,
  output logic [CNT_W-1:0] count_o
);
  logic launch_q;
  logic read_bit;

  xbit_launch u_launch (
    .clk_i  (src_clk_i),
    .rst_ni (src_rst_ni),
    .en_i   (send_en_i),
    .d_i    (send_bit_i),
    .q_o    (launch_q)
  );

  xbit_capture #(.STAGES(SYNC_STAGES)) u_capture (
    .clk_i   (dst_clk_i),
    .rst_ni  (dst_rst_ni),
    .async_i (launch_q),
    .sync_o  (read_bit)
  );

  xbit_step_counter #(.W(CNT_W)) u_counter (
    .clk_i  (dst_clk_i),
    .rst_ni (dst_rst_ni),
    .step_i (read_bit),
    .cnt_o  (count_o)
  );

  assign read_bit_o = read_bit;
endmodule

// File: rtl/xdom_bit_counter_chk.sv
module xdom_bit_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             src_clk_i,
  input logic             src_rst_ni,
  input logic             send_en_i,
  input logic             send_bit_i,
  input logic             dst_clk_i,
  input logic             dst_rst_ni,
  input logic             launch_q,
  input logic             read_bit_o,
  input logic [CNT_W-1:0] count_o
);
  // destination edges seen since reset release, saturating at 2
  logic [1:0] dst_age_q;
  always_ff @(posedge dst_clk_i or negedge dst_rst_ni) begin
    if (!dst_rst_ni)          dst_age_q <= 2'd0;
    else if (dst_age_q != 2'd2) dst_age_q <= dst_age_q + 2'd1;
  end

  assert_src_reset_clears_R1: assert property (@(posedge src_clk_i)
    !src_rst_ni |-> (launch_q == 1'b0));

  assert_dst_reset_clears_R2: assert property (@(posedge dst_clk_i)
    !dst_rst_ni |-> (read_bit_o == 1'b0 && count_o == '0));

  assert_send_load_R3: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    send_en_i |=> (launch_q == $past(send_bit_i)));

  assert_send_hold_R3: assert property (@(posedge src_clk_i) disable iff (!src_rst_ni)
    !send_en_i |=> $stable(launch_q));

  assert_two_edge_path_R4: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    (dst_age_q == 2'd2) |-> (read_bit_o == $past(launch_q, 2)));

  assert_count_step_R5: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    count_o == $past(count_o) + CNT_W'($past(read_bit_o)));
endmodule

bind xdom_bit_counter xdom_bit_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .src_clk_i  (src_clk_i),
  .src_rst_ni (src_rst_ni),
  .send_en_i  (send_en_i),
  .send_bit_i (send_bit_i),
  .dst_clk_i  (dst_clk_i),
  .dst_rst_ni (dst_rst_ni),
  .launch_q   (launch_q),
  .read_bit_o (read_bit_o),
  .count_o    (count_o)
);

// File: tb/xdom_bit_counter_bench.sv
`timescale 1ns/100ps
module xdom_bit_counter_bench;
  logic        src_clk = 1'b0;
  logic        dst_clk = 1'b0;
  logic        src_rst_n = 1'b1;
  logic        dst_rst_n = 1'b1;
  logic        send_en = 1'b0;
  logic        send_bit = 1'b0;
  logic        read_bit;
  logic [31:0] count;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // 250 MHz destination clock; 7 ns source clock, rising edges never coincide
  always #2.0 dst_clk = ~dst_clk;
  always #3.5 src_clk = ~src_clk;

  xdom_bit_counter u_xdom_bit_counter (
    .src_clk_i  (src_clk),
    .src_rst_ni (src_rst_n),
    .send_en_i  (send_en),
    .send_bit_i (send_bit),
    .dst_clk_i  (dst_clk),
    .dst_rst_ni (dst_rst_n),
    .read_bit_o (read_bit),
    .count_o    (count)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic dst_edges(int n);
    for (int i = 0; i < n; i++) @(posedge dst_clk);
    @(negedge dst_clk);
  endtask

  // drive on source falling edge, return right after the loading source edge
  task automatic drive_src(logic en, logic b);
    @(negedge src_clk);
    send_en  = en;
    send_bit = b;
    @(posedge src_clk);
  endtask

  task automatic t_reset;
    #0.5;
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    dst_edges(3);
    chk("R2", "read in reset", 32'(read_bit), 32'd0);
    chk("R2", "count in reset", count, 32'd0);
    @(negedge src_clk) src_rst_n = 1'b1;
    @(negedge dst_clk) dst_rst_n = 1'b1;
    dst_edges(4);
    chk("R1", "read after release", 32'(read_bit), 32'd0);
    chk("R5", "count idle after release", count, 32'd0);
  endtask

  task automatic t_latency(logic b);
    drive_src(1'b1, b);
    dst_edges(1);
    chk("R4", "old value after one edge", 32'(read_bit), 32'(!b));
    dst_edges(2);
    chk("R4", "new value by third edge", 32'(read_bit), 32'(b));
    chk("R3", "enabled send crossed", 32'(read_bit), 32'(b));
  endtask

  task automatic t_count_run(int n, logic b);
    logic [31:0] c0;
    @(negedge dst_clk);
    c0 = count;
    dst_edges(n);
    chk("R5", b ? "count stepped" : "count held", count, b ? c0 + 32'(n) : c0);
  endtask

  task automatic t_send_disabled;
    drive_src(1'b0, 1'b0);
    dst_edges(6);
    chk("R3", "disabled send ignored", 32'(read_bit), 32'd1);
    drive_src(1'b0, 1'b1);
  endtask

  task automatic t_src_reset;
    logic [31:0] c0;
    @(negedge src_clk) src_rst_n = 1'b0;
    @(negedge dst_clk);
    c0 = count;
    dst_edges(3);
    chk("R1", "read cleared by source reset", 32'(read_bit), 32'd0);
    chk("R1", "count not cleared", 32'(count >= c0 && count != 0), 32'd1);
    @(negedge src_clk) src_rst_n = 1'b1;
    @(posedge src_clk);
    dst_edges(3);
    chk("R1", "read after source release", 32'(read_bit), 32'd1);
  endtask

  task automatic t_dst_reset;
    drive_src(1'b0, 1'b0);
    dst_edges(2);
    dst_rst_n = 1'b0;
    #0.2;
    chk("R2", "count cleared at once", count, 32'd0);
    chk("R2", "read cleared at once", 32'(read_bit), 32'd0);
    @(negedge dst_clk) dst_rst_n = 1'b1;
    dst_edges(1);
    chk("R2", "read still low one edge after release", 32'(read_bit), 32'd0);
    dst_edges(2);
    chk("R2", "launch kept, read back to 1", 32'(read_bit), 32'd1);
    chk("R5", "count one step after recovery", count, 32'd1);
  endtask

  initial begin
    t_reset();
    t_latency(1'b1);
    t_count_run(10, 1'b1);
    t_send_disabled();
    t_latency(1'b0);
    t_count_run(8, 1'b0);
    t_latency(1'b1);
    t_count_run(5, 1'b1);
    t_src_reset();
    t_dst_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge dst_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule